// File: doc/BRIEF.md
# Handshake-Timed System Bus Master

This block issues single transfers on a shared parallel system bus whose cycle length is set by the addressed slave, not by a clock. A local requester presents a transfer kind (memory read, memory write, I/O read, I/O write or interrupt acknowledge), an address and, for writes, a data word. The master puts the address on the bus with a one-cycle address-latch pulse. It then lowers the single active-low command line that belongs to the requested kind and holds it until the slave answers on its Ready line.

Ready arrives with no relation to the local clock, so it passes through a two-flop synchroniser before the sequencer acts on it. Once Ready is seen, the command line is released on the next clock edge. Read data, including the interrupt vector fetched by an acknowledge cycle, is captured while Ready is high. The master then waits for the slave to drop Ready before it reports completion and becomes free again. A programmable timeout ends a cycle that gets no answer and reports a bus error. A busy flag shows that a cycle is in flight, and any request presented while it is high is dropped.

Top module: `sbus_master`

## Requirements
- R1: Kinds are encoded on `req_kind` as 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge. The lines {`mrd_n`,`mwr_n`,`ird_n`,`iwr_n`,`inta_n`} map to kinds 0..4 in that order. During a cycle exactly the matching line is low. A request with a kind of 5 to 7 is ignored: no address pulse and no busy.
- R2: `bus_ale` is high for exactly one clock, immediately before the command line falls. `bus_addr` equals the accepted address from that pulse until the command line rises.
- R3: The command line stays low until synchronised Ready is seen and rises on the next clock. With Ready raised k clocks after the command fell, the strobe is low for k+2 clocks.
- R4: On a completed read or acknowledge cycle, `rsp_rdata` holds the value on `bus_din` while Ready was high. It reads 0 after a write or a timed-out cycle.
- R5: `bus_den` is high, and `bus_dout` carries the request's write data, exactly while a write command line (memory or I/O) is low.
- R6: With `tmo_limit` = L > 0 and no Ready, the command line is low for exactly L clocks. The cycle then completes with `rsp_err` = 1. If Ready is seen in the same clock as the limit, Ready wins and `rsp_err` = 0.
- R7: With `tmo_limit` = 0 the timeout is off, and a cycle waits for Ready however long it takes.
- R8: After releasing the command line, the master waits until synchronised Ready is low before it signals completion. No new command line falls while Ready is high.
- R9: `busy` is high from the clock after a request is accepted until completion. Requests presented while busy have no effect on the bus.
- R10: After reset `busy`, `done`, `bus_ale`, `bus_den` and `rsp_err` are 0, and all command lines are high.
- R11: `done` is a one-clock pulse that coincides with `busy` returning to 0, with `rsp_rdata` and `rsp_err` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 3 | Transfer kind, encoding per R1 |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| tmo_limit | input | TW | Timeout in clocks, 0 disables |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Completion pulse |
| rsp_rdata | output | DW | Captured read data |
| rsp_err | output | 1 | Cycle ended by timeout |
| bus_addr | output | AW | Bus address lines |
| bus_dout | output | DW | Bus write data |
| bus_den | output | 1 | Data driver enable |
| bus_ale | output | 1 | Address latch pulse |
| mrd_n | output | 1 | Memory read command, active low |
| mwr_n | output | 1 | Memory write command, active low |
| ird_n | output | 1 | I/O read command, active low |
| iwr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| bus_din | input | DW | Bus read data |
| bus_ready | input | 1 | Asynchronous slave Ready |

## Verification
The hardest case to reach is a Ready that lands in the same clock as the timeout limit, because the synchroniser adds two clocks that the requester cannot see. The bench models a slave whose response delay is chosen so that delay plus two equals the limit, which forces the tie. It also picks slaves that keep Ready high for several clocks after release, to exercise the wait for Ready to drop. Requests are injected while busy to show they never disturb the bus.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int unsigned NUM_KINDS = 5;

    typedef enum logic [2:0] {
        K_MRD  = 3'd0,
        K_MWR  = 3'd1,
        K_IRD  = 3'd2,
        K_IWR  = 3'd3,
        K_INTA = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_REL
    } state_e;

    // active-high internal view of the command lines; mrd is the MSB
    typedef struct packed {
        logic mrd;
        logic mwr;
        logic ird;
        logic iwr;
        logic inta;
    } cmd_t;

    function automatic logic kind_valid(logic [2:0] k);
        return k < 3'(NUM_KINDS);
    endfunction

    function automatic logic kind_writes(kind_e k);
        return (k == K_MWR) || (k == K_IWR);
    endfunction

    function automatic cmd_t kind_to_cmd(kind_e k);
        cmd_t c;
        c = '0;
        case (k)
            K_MRD:   c.mrd  = 1'b1;
            K_MWR:   c.mwr  = 1'b1;
            K_IRD:   c.ird  = 1'b1;
            K_IWR:   c.iwr  = 1'b1;
            K_INTA:  c.inta = 1'b1;
            default: c      = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbus_timer.sv
module sbus_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign expire = run && (limit != '0) && (cnt >= limit - TW'(1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (run && limit != '0 && $stable(limit)) |-> (cnt < limit));
endmodule

// File: rtl/sbus_cmd_drv.sv
module sbus_cmd_drv
    import sbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  kind_e       kind,
    input  logic        active,
    output logic [4:0]  cmd_n,
    output logic        den
);
    cmd_t cmd;

    always_comb begin
        cmd = active ? kind_to_cmd(kind) : '0;
    end

    assign cmd_n = ~cmd;
    assign den   = active && kind_writes(kind);

    // R1
    one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~cmd_n) <= 1);

    // R5
    den_write_chk: assert property (@(posedge clk) disable iff (rst)
        den |-> (!cmd_n[3] || !cmd_n[1]));
endmodule

// File: rtl/sbus_master.sv
module sbus_master
    import sbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int TW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] tmo_limit,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_den,
    output logic          bus_ale,
    output logic          mrd_n,
    output logic          mwr_n,
    output logic          ird_n,
    output logic          iwr_n,
    output logic          inta_n,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_ready
);
    state_e        state;
    kind_e         kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          err_q;
    logic          done_q;
    logic          rdy_s;
    logic          expire;
    logic [4:0]    cmd_n;

    sbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_ready),
        .q   (rdy_s)
    );

    sbus_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == S_CMD),
        .limit  (tmo_limit),
        .expire (expire)
    );

    sbus_cmd_drv u_cmd (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind_q),
        .active (state == S_CMD),
        .cmd_n  (cmd_n),
        .den    (bus_den)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            kind_q  <= K_MRD;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid && kind_valid(req_kind)) begin
                        kind_q  <= kind_e'(req_kind);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        state   <= S_ADDR;
                    end
                end
                S_ADDR: begin
                    state <= S_CMD;
                end
                S_CMD: begin
                    if (rdy_s) begin
                        rdata_q <= kind_writes(kind_q) ? '0 : bus_din;
                        err_q   <= 1'b0;
                        state   <= S_REL;
                    end else if (expire) begin
                        rdata_q <= '0;
                        err_q   <= 1'b1;
                        state   <= S_REL;
                    end
                end
                S_REL: begin
                    if (!rdy_s) begin
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;
    assign bus_addr  = addr_q;
    assign bus_dout  = wdata_q;
    assign bus_ale   = (state == S_ADDR);
    assign {mrd_n, mwr_n, ird_n, iwr_n, inta_n} = cmd_n;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_CMD || state == S_REL) |-> $stable(bus_addr));

    // R2
    ale_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(&cmd_n) |-> $past(bus_ale));

    // R6
    tmo_end_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !rdy_s) |=> (&cmd_n && rsp_err));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(&cmd_n) |-> !rdy_s);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/sim_sbus_master.sv
`timescale 1ns/1ps
module sim_sbus_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  tmo_limit = 8'd16;
    logic        busy, done, rsp_err, bus_den, bus_ale;
    logic [15:0] rsp_rdata, bus_addr, bus_dout;
    logic        mrd_n, mwr_n, ird_n, iwr_n, inta_n;
    logic [15:0] bus_din = '0;
    logic        bus_ready = 1'b0;

    int nvec = 0;
    int nerr = 0;

    // slave model state and expectations
    int  s_delay = 1, s_hold = 0, s_cnt = 0, s_low = 0, s_hold_cnt = 0, ale_cnt = 0;
    bit  s_noready = 0;
    int  exp_kind = 0;
    logic [15:0] exp_addr = '0, exp_wdata = '0, cap_w = '0;
    bit  prev_low = 0, prev_ale = 0;

    always #2 clk = ~clk;

    sbus_master u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_den(bus_den), .bus_ale(bus_ale),
        .mrd_n(mrd_n), .mwr_n(mwr_n), .ird_n(ird_n), .iwr_n(iwr_n), .inta_n(inta_n),
        .bus_din(bus_din), .bus_ready(bus_ready)
    );

    function automatic logic [15:0] sdata(logic [15:0] a, int k);
        return a ^ 16'hA5C3 ^ 16'(k * 16'h0111);
    endfunction

    function automatic bit is_wr(int k);
        return (k == 1) || (k == 3);
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // slave and bus monitor, all on the falling edge
    always @(negedge clk) begin
        bit low;
        if (!rst) begin
            low = !(mrd_n & mwr_n & ird_n & iwr_n & inta_n);
            if (low) begin
                if (!prev_low) begin
                    chk(prev_ale, "R2 ale before strobe", prev_ale, 1);
                    chk(!bus_ready, "R8 strobe while ready high", bus_ready, 0);
                    s_cnt = 0;
                end
                s_cnt++;
                s_low++;
                chk({mrd_n, mwr_n, ird_n, iwr_n, inta_n} == ~(5'b10000 >> exp_kind),
                    "R1 strobe select", {mrd_n, mwr_n, ird_n, iwr_n, inta_n},
                    ~(5'b10000 >> exp_kind));
                chk(bus_addr == exp_addr, "R2 address hold", bus_addr, exp_addr);
                chk(bus_den == is_wr(exp_kind), "R5 data enable", bus_den, is_wr(exp_kind));
                if (is_wr(exp_kind))
                    chk(bus_dout == exp_wdata, "R5 write data", bus_dout, exp_wdata);
                if (!s_noready && s_cnt == s_delay) begin
                    bus_ready = 1'b1;
                    bus_din = sdata(exp_addr, exp_kind);
                    cap_w = bus_dout;
                    s_hold_cnt = s_hold;
                end
            end else if (bus_ready) begin
                if (s_hold_cnt > 0) s_hold_cnt--;
                else bus_ready = 1'b0;
            end
            if (bus_ale) ale_cnt++;
            prev_low = low;
            prev_ale = bus_ale;
        end
    end

    task automatic txn(int kind, logic [15:0] addr, logic [15:0] wdata, int delay,
                       int hold, bit noready, int limit, bit poke);
        int w;
        logic [15:0] er;
        int ew;
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_kind = kind; exp_addr = addr; exp_wdata = wdata;
        s_delay = delay; s_hold = hold; s_noready = noready;
        tmo_limit = 8'(limit); ale_cnt = 0; s_low = 0;
        req_valid = 1'b1; req_kind = 3'(kind); req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            chk(busy, "R9 busy after accept", busy, 1);
            req_valid = 1'b1; req_kind = 3'((kind + 1) % 5);
            req_addr = ~addr; req_wdata = ~wdata;
            @(negedge clk);
            req_valid = 1'b0;
        end
        w = 0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        if (w >= 5000) begin
            chk(0, "R11 watchdog no done", 0, 1);
            return;
        end
        er = (noready || is_wr(kind)) ? 16'h0 : sdata(addr, kind);
        ew = noready ? limit : delay + 2;
        chk(rsp_err == noready, noready ? "R6 timeout error" : "R3 no error",
            rsp_err, noready);
        chk(rsp_rdata == er, "R4 read data", rsp_rdata, er);
        chk(s_low == ew, noready ? "R6 strobe width" : "R3 strobe width", s_low, ew);
        chk(ale_cnt == 1, "R9 one address pulse", ale_cnt, 1);
        chk(!busy, "R11 busy clear with done", busy, 0);
        chk(!bus_ready, "R8 done after ready low", bus_ready, 0);
        if (is_wr(kind) && !noready)
            chk(cap_w == wdata, "R5 slave saw data", cap_w, wdata);
        @(negedge clk);
        chk(!done, "R11 done one cycle", done, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !bus_ale && !bus_den && !rsp_err, "R10 reset outputs",
            {busy, done, bus_ale, bus_den, rsp_err}, 0);
        chk({mrd_n, mwr_n, ird_n, iwr_n, inta_n} == 5'h1F, "R10 reset strobes",
            {mrd_n, mwr_n, ird_n, iwr_n, inta_n}, 5'h1F);

        // R1 invalid kind ignored
        ale_cnt = 0;
        req_valid = 1'b1; req_kind = 3'd6; req_addr = 16'h1234;
        @(negedge clk); req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && ale_cnt == 0, "R1 invalid kind ignored", ale_cnt, 0);

        // directed corners
        txn(0, 16'h0100, 16'h0, 1, 0, 0, 16, 0);      // R3 fastest slave
        txn(1, 16'h0200, 16'hBEEF, 5, 3, 0, 16, 1);   // R5 R8 R9 write, long ready
        txn(4, 16'h0000, 16'h0, 3, 0, 0, 16, 0);      // R4 acknowledge vector
        txn(2, 16'h0300, 16'h0, 6, 1, 0, 8, 0);       // R6 ready ties with limit
        txn(3, 16'h0400, 16'h1111, 0, 0, 1, 4, 0);    // R6 timeout
        txn(0, 16'h0500, 16'h0, 0, 0, 1, 1, 0);       // R6 limit of one
        txn(2, 16'h0600, 16'h0, 40, 2, 0, 0, 0);      // R7 timeout disabled

        for (int i = 0; i < 150; i++) begin
            int k = int'($urandom % 5);
            bit nr = ($urandom % 10) == 0;
            int d = 1 + int'($urandom % 8);
            txn(k, 16'($urandom), 16'($urandom), d, int'($urandom % 4), nr,
                nr ? 2 + int'($urandom % 9) : 12 + int'($urandom % 9), ($urandom % 3) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nvec++; nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule